// File: doc/BRIEF.md
# Compare-Match Toggle Timer

This block is a 24-bit up-counting timer that drives one output pin. A timer tick comes either from the system clock divided by two or from an external prescaler strobe. On each tick the counter advances. When the new count equals a programmed compare value, a match event occurs. In toggle mode the match inverts the pin. In pulse mode the match drives the pin to its active level for one tick period.

When the timer is switched on, the counter starts from a load value and the pin is preset from an invert bit. A reload option decides what happens after a match. With reload set, the counter returns to the load value on the next tick. With reload clear, it keeps counting through the match. Match and overflow events set sticky status flags, which software clears by writing 1. An interrupt line reports the flags when interrupts are enabled.

Software reaches the timer through a synchronous write strobe and a combinational read port. The register map is: address 0 holds control, 1 holds load, 2 holds compare, 3 holds status, and 4 returns the count (read only). Any other address reads as zero. In the control word, bit 0 is enable, bits 4:1 are the mode code, bit 5 is invert, bit 6 is reload, bit 7 is interrupt enable and bit 8 selects the prescaler strobe. In the status word, bit 0 is the compare flag and bit 1 is the overflow flag.

Top module: `cmp_toggle_timer`

## Requirements
- R1: On the clock edge after enable changes from 0 to 1, the count equals the load register and the output equals the invert bit.
- R2: While running, the counter advances on every second system clock. With control bit 8 set, it advances instead on each clock where the prescaler strobe is high.
- R3: In toggle mode (mode code 0010), a tick whose new count equals the compare register inverts the output and sets the compare flag (status bit 0).
- R4: With reload set (control bit 6), the tick after a matching tick loads the counter from the load register.
- R5: With reload clear, the counter increments by one on every tick, including the tick after a match.
- R6: In pulse mode (mode code 0001), a matching tick drives the output to the inverse of the invert bit for exactly one tick period. Otherwise the output equals the invert bit.
- R7: A tick that increments the counter from 0xFFFFFF wraps it to 0 and sets the overflow flag (status bit 1).
- R8: The interrupt output is high exactly when interrupt enable (control bit 7) is 1 and at least one status flag is set.
- R9: Writing 1 to a status bit clears that flag. A match or overflow on the same clock as the clear wins, and the flag stays set.
- R10: While enable is 0 the count and the output hold their values. A mode code other than 0001 or 0010 stops the counter.
- R11: Control, load and compare read back as written at addresses 0, 1 and 2. The count reads at address 4, and other unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data for the addressed register |
| pre_tick | input | 1 | Prescaler strobe, used as the tick when selected |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
The case of interest is a flag-clear write landing in the same cycle as a new match or overflow. To provoke it, the bench writes 1 to both status bits on every clock while a short reload period produces matches every few cycles. Some clears therefore coincide with events. A behavioural model applies the rule that the event wins. The status read-back and the interrupt line are compared with that model on every clock, so an overlap resolved the wrong way shows up as a mismatch.

// File: rtl/cmp_timer_pkg.sv
// Package: shared widths, register addresses, mode codes and the control
// word layout of the compare-match toggle timer.
package cmp_timer_pkg;

    localparam int CNT_W  = 24;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 9;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP    = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;

    localparam logic [3:0] MODE_PULSE  = 4'b0001;
    localparam logic [3:0] MODE_TOGGLE = 4'b0010;

    // Control word, bit 0 (en) up to bit 8 (use_pre).
    typedef struct packed {
        logic       use_pre;
        logic       ien;
        logic       reload;
        logic       inv;
        logic [3:0] mode;
        logic       en;
    } ctrl_t;

endpackage

// File: rtl/ctt_regs.sv
// Register file of the timer: control, load and compare registers, the two
// sticky status flags with write-one-to-clear, the read mux and the
// interrupt gate. Assumes events arrive as single-cycle strobes from the
// core. An event wins over a clear in the same cycle.
module ctt_regs
    import cmp_timer_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic          cmp_evt,
    input  logic          ovf_evt,
    input  logic [W-1:0]  count,
    output ctrl_t         ctrl,
    output logic [W-1:0]  load_val,
    output logic [W-1:0]  cmp_val,
    output logic          cmp_flag,
    output logic          ovf_flag,
    output logic [W-1:0]  rdata,
    output logic          irq
);

    localparam int PAD_CTRL = W - CTRL_W;
    localparam int PAD_STAT = W - 2;

    logic wr_ctrl, wr_load, wr_cmp, wr_stat;

    // Purpose: decode which register a write targets.
    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_load = wr_en && (addr == A_LOAD);
        wr_cmp  = wr_en && (addr == A_CMP);
        wr_stat = wr_en && (addr == A_STATUS);
    end

    // Purpose: hold the software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            load_val <= '0;
            cmp_val  <= '0;
        end else begin
            if (wr_ctrl) ctrl     <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_load) load_val <= wdata;
            if (wr_cmp)  cmp_val  <= wdata;
        end
    end

    // Purpose: sticky flags, where a new event overrides a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            cmp_flag <= cmp_evt | (cmp_flag & ~(wr_stat & wdata[0]));
            ovf_flag <= ovf_evt | (ovf_flag & ~(wr_stat & wdata[1]));
        end
    end

    // Purpose: return the addressed register to the read port.
    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = {{PAD_CTRL{1'b0}}, ctrl};
            A_LOAD:   rdata = load_val;
            A_CMP:    rdata = cmp_val;
            A_STATUS: rdata = {{PAD_STAT{1'b0}}, ovf_flag, cmp_flag};
            A_COUNT:  rdata = count;
            default:  rdata = '0;
        endcase
    end

    // Purpose: interrupt request from the gated flags.
    always_comb begin
        irq = ctrl.ien & (cmp_flag | ovf_flag);
    end

endmodule

// File: rtl/ctt_tick.sv
// Timer tick source. While the timer runs, it emits a strobe every second
// clock, or passes the external prescaler strobe through when that source
// is selected. The divider restarts in phase 0 whenever the timer is not
// running, so the first divided tick comes two clocks after start.
module ctt_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_pre,
    input  logic pre_tick,
    output logic tick
);

    logic div_q;

    // Purpose: divide-by-two phase, held at 0 while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= 1'b0;
        end else if (!run) begin
            div_q <= 1'b0;
        end else begin
            div_q <= ~div_q;
        end
    end

    // Purpose: choose the tick source.
    always_comb begin
        tick = run & (use_pre ? pre_tick : div_q);
    end

endmodule

// File: rtl/ctt_core.sv
// Counter and output stage. On the first enabled clock it loads the counter
// and presets the pin. On each tick it advances or reloads the counter,
// detects a compare match on the new count, detects wrap-around, and
// updates the pin for toggle or pulse mode. Any other mode code stops the
// timer. Assumes all control inputs are registered.
module ctt_core
    import cmp_timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [3:0]   mode,
    input  logic         inv,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_val,
    input  logic         tick,
    output logic         en_q,
    output logic         run,
    output logic         pend,
    output logic [W-1:0] count,
    output logic         tmr_out,
    output logic         cmp_evt,
    output logic         ovf_evt
);

    logic         start;
    logic         mode_ok;
    logic         at_max;
    logic [W-1:0] next_val;

    // Purpose: start strobe, run qualifier and next count.
    always_comb begin
        mode_ok  = (mode == MODE_TOGGLE) || (mode == MODE_PULSE);
        start    = en & ~en_q;
        run      = en & en_q & mode_ok;
        at_max   = &count;
        next_val = pend ? load_val : count + 1'b1;
        cmp_evt  = tick & (next_val == cmp_val);
        ovf_evt  = tick & ~pend & at_max;
    end

    // Purpose: remember the previous enable to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    // Purpose: counter register with the reload-pending marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            pend  <= 1'b0;
        end else if (start) begin
            count <= load_val;
            pend  <= 1'b0;
        end else if (tick) begin
            count <= next_val;
            pend  <= cmp_evt & reload;
        end
    end

    // Purpose: output pin, preset at start and updated on ticks per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_out <= 1'b0;
        end else if (start) begin
            tmr_out <= inv;
        end else if (tick) begin
            if (mode == MODE_TOGGLE) begin
                if (cmp_evt) tmr_out <= ~tmr_out;
            end else begin
                tmr_out <= cmp_evt ? ~inv : inv;
            end
        end
    end

endmodule

// File: rtl/cmp_toggle_timer.sv
// Top level of the compare-match toggle timer. It ties together the
// register file, the tick source and the counter core. All state uses a
// synchronous active-low reset on clk.
module cmp_toggle_timer
    import cmp_timer_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          pre_tick,
    output logic          tmr_out,
    output logic          irq
);

    ctrl_t        ctrl;
    logic [W-1:0] load_val, cmp_val, count;
    logic         cmp_flag, ovf_flag, cmp_evt, ovf_evt;
    logic         en_q, run, pend, tick;

    ctt_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cmp_evt(cmp_evt), .ovf_evt(ovf_evt), .count(count),
        .ctrl(ctrl), .load_val(load_val), .cmp_val(cmp_val),
        .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .rdata(rdata), .irq(irq)
    );

    ctt_tick u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .use_pre(ctrl.use_pre),
        .pre_tick(pre_tick), .tick(tick)
    );

    ctt_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .mode(ctrl.mode),
        .inv(ctrl.inv), .reload(ctrl.reload), .load_val(load_val),
        .cmp_val(cmp_val), .tick(tick), .en_q(en_q), .run(run), .pend(pend),
        .count(count), .tmr_out(tmr_out), .cmp_evt(cmp_evt), .ovf_evt(ovf_evt)
    );

endmodule

// File: rtl/ctt_chk.sv
// Assertion checker for the compare-match toggle timer. It is bound into
// the top module and observes the timer's ports and internal strobes.
module ctt_chk
    import cmp_timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         en_q,
    input logic         inv,
    input logic [3:0]   mode,
    input logic         ien,
    input logic         use_pre,
    input logic         tick,
    input logic         cmp_evt,
    input logic         pend,
    input logic [W-1:0] load_val,
    input logic [W-1:0] count,
    input logic         tmr_out,
    input logic         cmp_flag,
    input logic         ovf_flag,
    input logic         irq
);

    AST_START_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !en_q) |=> (tmr_out == $past(inv) && count == $past(load_val))); // R1

    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !use_pre) |=> (!tick || use_pre)); // R2

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmp_evt && mode == MODE_TOGGLE) |=> (tmr_out != $past(tmr_out))); // R3

    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pend) |=> (count == $past(load_val))); // R4

    AST_FREE_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pend) |=> (count == W'($past(count) + 1'b1))); // R5

    AST_PULSE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmp_evt && mode == MODE_PULSE) |=> (tmr_out == !$past(inv))); // R6

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pend && (&count)) |=> (ovf_flag && count == '0)); // R7

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmp_evt && ien) |=> (irq || !ien)); // R8

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmp_evt) |=> cmp_flag); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !en_q) |=> ($stable(tmr_out) && $stable(count))); // R10

endmodule

bind cmp_toggle_timer ctt_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .en_q(en_q), .inv(ctrl.inv),
    .mode(ctrl.mode), .ien(ctrl.ien), .use_pre(ctrl.use_pre), .tick(tick),
    .cmp_evt(cmp_evt), .pend(pend), .load_val(load_val), .count(count),
    .tmr_out(tmr_out), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/cmp_toggle_timer_tb.sv
module cmp_toggle_timer_tb;

    localparam int MASK = 24'hFFFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd4;
    logic [23:0] wdata = '0;
    logic        pre_tick = 1'b0;
    logic [23:0] rdata;
    logic        tmr_out, irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cmp_toggle_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pre_tick(pre_tick), .tmr_out(tmr_out), .irq(irq)
    );

    // behavioural reference state
    int m_ctrl, m_load, m_cmp, m_cnt;
    bit m_cf, m_of, m_out, m_enq, m_div, m_pend;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_rd(input int a);
        case (a)
            0: return m_ctrl;
            1: return m_load;
            2: return m_cmp;
            3: return {m_of, m_cf};
            4: return m_cnt;
            default: return 0;
        endcase
    endfunction

    // reference model updated on each edge, compared 3 ns later
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_load = 0; m_cmp = 0; m_cnt = 0;
            m_cf = 0; m_of = 0; m_out = 0; m_enq = 0; m_div = 0; m_pend = 0;
        end else begin
            bit en, inv, rel, pre, start, run, tk, mevt, oevt, clr;
            int mode, nxt;
            en = m_ctrl[0]; mode = (m_ctrl >> 1) & 15; inv = m_ctrl[5];
            rel = m_ctrl[6]; pre = m_ctrl[8];
            start = en && !m_enq;
            run = en && m_enq && (mode == 1 || mode == 2);
            tk = run && (pre ? pre_tick : m_div);
            nxt = m_pend ? m_load : ((m_cnt + 1) & MASK);
            mevt = tk && (nxt == m_cmp);
            oevt = tk && !m_pend && (m_cnt == MASK);
            m_enq = en;
            m_div = run ? !m_div : 1'b0;
            if (start) begin
                m_cnt = m_load; m_out = inv; m_pend = 0;
            end else if (tk) begin
                m_cnt = nxt;
                m_pend = mevt && rel;
                if (mode == 2) m_out = mevt ? !m_out : m_out;
                else m_out = mevt ? !inv : inv;
            end
            clr = wr_en && addr == 3;
            m_cf = mevt || (m_cf && !(clr && wdata[0]));
            m_of = oevt || (m_of && !(clr && wdata[1]));
            if (wr_en && addr == 0) m_ctrl = int'(wdata[8:0]);
            if (wr_en && addr == 1) m_load = int'(wdata);
            if (wr_en && addr == 2) m_cmp = int'(wdata);
        end
        #3;
        if (!done) begin
            int md;
            md = (m_ctrl >> 1) & 15;
            chk(md == 1 ? "R6 pin" : (md == 2 ? "R3 pin" : "R10 pin"), int'(tmr_out), int'(m_out));
            chk("R8 irq", int'(irq), int'(m_ctrl[7] && (m_cf || m_of)));
            chk(addr == 4 ? "R2 count" : (addr == 3 ? "R9 status" : "R11 readback"),
                int'(rdata), exp_rd(int'(addr)));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = 24'(d);
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd4;
    endtask

    function automatic int cw(input int en, input int mode, input int inv,
                              input int rel, input int ie, input int pre);
        return (pre << 8) | (ie << 7) | (rel << 6) | (inv << 5) | (mode << 1) | en;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int ld, input int cp);
        wr(0, 0); wr(3, 3); wr(1, ld); wr(2, cp);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset pin", int'(tmr_out), 0);
        chk("R8 reset irq", int'(irq), 0);
        chk("R2 reset count", int'(rdata), 0);

        // toggle with reload, invert 1: start preset
        setup(5, 9);
        wr(0, cw(1, 2, 1, 1, 1, 0));
        @(negedge clk);
        chk("R1 start count", int'(rdata), 5);
        chk("R1 start pin", int'(tmr_out), 1);
        idle(60);
        addr = 3'd0; @(negedge clk);
        chk("R11 ctrl readback", int'(rdata), cw(1, 2, 1, 1, 1, 0));
        addr = 3'd2; @(negedge clk);
        chk("R11 cmp readback", int'(rdata), 9);
        addr = 3'd6; @(negedge clk);
        chk("R11 unused addr", int'(rdata), 0);
        addr = 3'd4;

        // disable freezes pin and count
        begin
            int c0; bit p0;
            wr(0, cw(0, 2, 1, 1, 1, 0));
            @(negedge clk);
            c0 = int'(rdata); p0 = tmr_out;
            idle(10);
            chk("R10 frozen count", int'(rdata), c0);
            chk("R10 frozen pin", int'(tmr_out), int'(p0));
        end

        // interrupts disabled: flags set, irq low (R8), invert 0, reload
        setup(0, 3);
        wr(0, cw(1, 2, 0, 1, 0, 0));
        idle(40);
        chk("R8 gated irq", int'(irq), 0);

        // free-running through match and wrap (R5, R7)
        setup(24'hFFFFF0, 24'hFFFFF4);
        wr(0, cw(1, 2, 0, 0, 1, 0));
        idle(50);
        addr = 3'd3; @(negedge clk);
        chk("R7 both flags", int'(rdata), 3);
        addr = 3'd4;

        // pulse mode, both polarities (R6)
        setup(0, 3);
        wr(0, cw(1, 1, 0, 1, 1, 0));
        idle(40);
        setup(10, 12);
        wr(0, cw(1, 1, 1, 1, 1, 0));
        idle(40);

        // prescaler strobe as tick (R2)
        setup(0, 4);
        wr(0, cw(1, 2, 0, 1, 1, 1));
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            pre_tick = (i % 3 == 0) || (i % 7 == 0);
        end
        pre_tick = 1'b0;

        // clear storm overlapping events (R9)
        setup(0, 2);
        wr(0, cw(1, 2, 0, 1, 1, 0));
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd3; wdata = 24'd3;
        idle(40);
        wr_en = 1'b0; addr = 3'd4;

        // overflow clear storm (R9, R7)
        setup(24'hFFFFFE, 24'h000005);
        wr(0, cw(1, 2, 0, 0, 1, 0));
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd3; wdata = 24'd2;
        idle(20);
        wr_en = 1'b0; addr = 3'd4;

        // unsupported mode code stops counting (R10)
        setup(7, 20);
        wr(0, cw(1, 3, 0, 1, 1, 0));
        idle(12);
        chk("R10 bad mode count", int'(rdata), 7);

        // reload value check after match (R4)
        setup(100, 101);
        wr(0, cw(1, 2, 0, 1, 0, 0));
        idle(8);
        chk("R4 reload wraps window", int'(rdata >= 24'd100 && rdata <= 24'd101), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule